// File: doc/BRIEF.md
# Serial Control Register Port

This block is a write-only, three-wire control port for a stereo audio converter. A host shifts 16-bit frames in on a data line, one bit for each rising edge of a serial clock, with the most significant bit first. A rising edge on a latch line ends the frame. Two address bits inside the word choose one of four program registers to update. An active-low select input decides whether a latched frame is accepted at all.

The three serial lines and the select line are asynchronous to the system clock. They pass through a synchronizer, and the block detects their edges in the system clock domain. The decoded fields come out as plain level outputs. The two attenuation codes are double-buffered. A code written with its load bit clear is not applied, and only a write that carries the load bit set changes the attenuation outputs. A common-attenuation mode makes the right channel output follow the left channel code.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset the outputs are: both attenuation codes 8'hFF, mute 0, deemph 0, dac_off 0, word_sel 2'b00, i2s 0, lr_pol 0, atten_common 0, slow_roll 0, phase_inv 0, clk_half 0, fs_sel 2'b10 and zero_det 0.
- R2: A frame is sampled on rising edges of `mc_i`, most significant bit first. It is committed on a rising edge of `ml_i`. Word bits 10:9 select the target register (0 left attenuation, 1 right attenuation, 2 core control, 3 interface control), and that register alone changes.
- R3: A core-control write (address 2) sets mute from bit 0, deemph from bit 1, dac_off from bit 2 and word_sel from bits 4:3. Bits 15:11 and 8:5 have no effect.
- R4: An interface-control write (address 3) sets i2s from bit 0, lr_pol from bit 1, atten_common from bit 2, slow_roll from bit 3, phase_inv from bit 4, clk_half from bit 5, fs_sel from bits 7:6 and zero_det from bit 8.
- R5: An address-0 write with bit 8 set puts bits 7:0 on `atten_l_o`. With bit 8 clear, `atten_l_o` keeps its value.
- R6: An address-1 write with bit 8 set applies bits 7:0 as the right attenuation code. With bit 8 clear, the right code keeps its value.
- R7: If `cs_n_i` is high when `ml_i` rises, the frame is discarded and no output changes.
- R8: If fewer than 16 `mc_i` rising edges arrive between two latch edges, the frame is discarded. If more than 16 arrive, the last 16 bits form the word.
- R9: While atten_common is 1, `atten_r_o` equals `atten_l_o`. Once atten_common is cleared, the stored right code appears again, including any code loaded while common mode was on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ml_i | input | 1 | Latch line; a rising edge commits the frame |
| mc_i | input | 1 | Serial clock; data sampled on its rising edge |
| md_i | input | 1 | Serial data, MSB first |
| cs_n_i | input | 1 | Active-low select; change only while `ml_i` is high |
| atten_l_o | output | 8 | Applied left attenuation code |
| atten_r_o | output | 8 | Applied right attenuation code (left code in common mode) |
| mute_o | output | 1 | Soft mute request |
| deemph_o | output | 1 | De-emphasis enable |
| dac_off_o | output | 1 | Forces the converter output to bipolar zero |
| word_sel_o | output | 2 | Input word length and format select |
| i2s_o | output | 1 | Input framing: 0 right-justified, 1 I2S |
| lr_pol_o | output | 1 | Word-clock polarity: 0 left on high |
| atten_common_o | output | 1 | Left code drives both channels |
| slow_roll_o | output | 1 | Slow roll-off filter select |
| phase_inv_o | output | 1 | Output phase inversion |
| clk_half_o | output | 1 | Clock output divided by two |
| fs_sel_o | output | 2 | De-emphasis sample-rate select |
| zero_det_o | output | 1 | Zero-detect mute enable |

## Verification
A corrupted shift register or bit counter makes the wrong register or field change a few system clocks after the latch edge. The cause can be a bit lost to edge detection, a wrong bit order, or a count that does not saturate. The error remains visible until the next write to that register. A load-bit or select fault shows up as an attenuation or control output that moves when it should hold, or holds when it should move. Every frame is therefore followed by a comparison of the whole output set about ten clocks after the latch edge. Frames with the select line high, short frames and long frames sit between normal writes, so a stray update cannot be hidden by a later one.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

  localparam int FRAME_W  = 16;
  localparam int ATT_W    = 8;
  localparam int ADDR_LO  = 9;
  localparam int ADDR_HI  = 10;
  localparam int LOAD_BIT = 8;
  localparam int N_CHAN   = 2;

  typedef enum logic [1:0] {
    SEL_ATT_L = 2'd0,
    SEL_ATT_R = 2'd1,
    SEL_CORE  = 2'd2,
    SEL_IFACE = 2'd3
  } reg_sel_e;

  // core control register image, bit 4 down to bit 0
  typedef struct packed {
    logic [1:0] word_sel;
    logic       dac_off;
    logic       deemph;
    logic       mute;
  } core_reg_t;

  // interface control register image, bit 8 down to bit 0
  typedef struct packed {
    logic       zero_det;
    logic [1:0] fs_sel;
    logic       clk_half;
    logic       phase_inv;
    logic       slow_roll;
    logic       att_common;
    logic       lr_pol;
    logic       i2s;
  } iface_reg_t;

  localparam int CORE_W  = $bits(core_reg_t);
  localparam int IFACE_W = $bits(iface_reg_t);

  localparam logic [ATT_W-1:0] ATT_RST   = '1;
  localparam core_reg_t        CORE_RST  = '0;
  localparam iface_reg_t       IFACE_RST = '{zero_det: 1'b0, fs_sel: 2'b10,
                                             clk_half: 1'b0, phase_inv: 1'b0,
                                             slow_roll: 1'b0, att_common: 1'b0,
                                             lr_pol: 1'b0, i2s: 1'b0};

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= d;
      end
      assign q = st_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] st_q;
      logic [STAGES-1:0][WIDTH-1:0] st_d;
      always_comb begin
        st_d = {st_q[STAGES-2:0], d};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
      end
      assign q = st_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  input  logic               clear,
  output logic [FRAME_W-1:0] word,
  output logic               full
);

  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int CNT_MAX = FRAME_W;

  logic [FRAME_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               word_en, cnt_en;

  always_comb begin
    word_en = shift_en;
    word_d  = {word_q[FRAME_W-2:0], bit_in};
    cnt_en  = clear | (shift_en & (cnt_q != CNT_W'(CNT_MAX)));
    cnt_d   = clear ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign word = word_q;
  assign full = (cnt_q == CNT_W'(CNT_MAX));

  // R2: each sampled bit enters at the LSB end, older bits move toward the MSB
  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[0] == $past(bit_in)) &&
                 (word[FRAME_W-1:1] == $past(word[FRAME_W-2:0])));

  // R8: a latch edge restarts the bit count, so the next frame is not full
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !full);

endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank
  import ctl3w_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [FRAME_W-1:0]    word,
  output logic [ATT_W-1:0]      att_l,
  output logic [ATT_W-1:0]      att_r,
  output core_reg_t             core,
  output iface_reg_t            iface
);

  reg_sel_e sel;
  logic     load;

  assign sel  = reg_sel_e'(word[ADDR_HI:ADDR_LO]);
  assign load = word[LOAD_BIT];

  logic [N_CHAN-1:0][ATT_W-1:0] att_q;

  generate
    for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
      logic             att_en;
      logic [ATT_W-1:0] att_d;
      always_comb begin
        att_en = commit & load & (sel == reg_sel_e'(ch));
        att_d  = word[ATT_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      att_q[ch] <= ATT_RST;
        else if (att_en) att_q[ch] <= att_d;
      end
    end
  endgenerate

  core_reg_t  core_q, core_d;
  iface_reg_t iface_q, iface_d;
  logic       core_en, iface_en;

  always_comb begin
    core_en  = commit & (sel == SEL_CORE);
    core_d   = core_reg_t'(word[CORE_W-1:0]);
    iface_en = commit & (sel == SEL_IFACE);
    iface_d  = iface_reg_t'(word[IFACE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       core_q <= CORE_RST;
    else if (core_en) core_q <= core_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        iface_q <= IFACE_RST;
    else if (iface_en) iface_q <= iface_d;
  end

  assign att_l = att_q[0];
  assign att_r = iface_q.att_common ? att_q[0] : att_q[1];
  assign core  = core_q;
  assign iface = iface_q;

  // R5: applied left code moves only on a loading address-0 commit
  p_left_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && load && sel == SEL_ATT_L) |=> $stable(att_q[0]));

  // R6: applied right code moves only on a loading address-1 commit
  p_right_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && load && sel == SEL_ATT_R) |=> $stable(att_q[1]));

  // R3: core fields hold unless address 2 is committed
  p_core_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && sel == SEL_CORE) |=> $stable(core));

  // R4: interface fields hold unless address 3 is committed
  p_iface_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && sel == SEL_IFACE) |=> $stable(iface));

endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import ctl3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ml_i,
  input  logic             mc_i,
  input  logic             md_i,
  input  logic             cs_n_i,
  output logic [ATT_W-1:0] atten_l_o,
  output logic [ATT_W-1:0] atten_r_o,
  output logic             mute_o,
  output logic             deemph_o,
  output logic             dac_off_o,
  output logic [1:0]       word_sel_o,
  output logic             i2s_o,
  output logic             lr_pol_o,
  output logic             atten_common_o,
  output logic             slow_roll_o,
  output logic             phase_inv_o,
  output logic             clk_half_o,
  output logic [1:0]       fs_sel_o,
  output logic             zero_det_o
);

  localparam int IN_W = 4;
  // order {cs_n, md, mc, ml}; latch idles high, select idles high
  localparam logic [IN_W-1:0] IN_RST = 4'b1001;

  logic [IN_W-1:0] raw_in, sync_in;
  logic            ml_s, mc_s, md_s, cs_n_s;

  assign raw_in = {cs_n_i, md_i, mc_i, ml_i};

  ctl3w_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  assign {cs_n_s, md_s, mc_s, ml_s} = sync_in;

  logic ml_prev_q, mc_prev_q;
  logic ml_rise, mc_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ml_prev_q <= 1'b1;
      mc_prev_q <= 1'b0;
    end else begin
      ml_prev_q <= ml_s;
      mc_prev_q <= mc_s;
    end
  end

  assign ml_rise = ml_s & ~ml_prev_q;
  assign mc_rise = mc_s & ~mc_prev_q;

  logic [FRAME_W-1:0] frame_word;
  logic               frame_full;
  logic               commit;

  ctl3w_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (mc_rise),
    .bit_in   (md_s),
    .clear    (ml_rise),
    .word     (frame_word),
    .full     (frame_full)
  );

  assign commit = ml_rise & ~cs_n_s & frame_full;

  core_reg_t  core;
  iface_reg_t iface;

  ctl3w_regbank u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .word   (frame_word),
    .att_l  (atten_l_o),
    .att_r  (atten_r_o),
    .core   (core),
    .iface  (iface)
  );

  assign mute_o         = core.mute;
  assign deemph_o       = core.deemph;
  assign dac_off_o      = core.dac_off;
  assign word_sel_o     = core.word_sel;
  assign i2s_o          = iface.i2s;
  assign lr_pol_o       = iface.lr_pol;
  assign atten_common_o = iface.att_common;
  assign slow_roll_o    = iface.slow_roll;
  assign phase_inv_o    = iface.phase_inv;
  assign clk_half_o     = iface.clk_half;
  assign fs_sel_o       = iface.fs_sel;
  assign zero_det_o     = iface.zero_det;

  logic [2*ATT_W+CORE_W+IFACE_W-1:0] out_vec;
  assign out_vec = {atten_l_o, atten_r_o, core, iface};

  // R7: a latch edge with select high leaves every output unchanged
  p_cs_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ml_rise && cs_n_s) |=> $stable(out_vec));

  // R8: a latch edge before 16 bits arrived leaves every output unchanged
  p_short_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ml_rise && !frame_full) |=> $stable(out_vec));

  // R9: in common mode the right output tracks the left output
  p_common_r9: assert property (@(posedge clk) disable iff (!rst_n)
    atten_common_o |-> (atten_r_o == atten_l_o));

endmodule

// File: tb/tb_ser_ctl_port.sv
module tb_ser_ctl_port;

  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ml = 1'b1, mc = 1'b0, md = 1'b0, cs_n = 1'b1;

  logic [7:0] atten_l, atten_r;
  logic mute, deemph, dac_off, i2s, lr_pol, atten_common, slow_roll, phase_inv, clk_half, zero_det;
  logic [1:0] word_sel, fs_sel;

  always #4 clk = ~clk;

  ser_ctl_port dut (
    .clk(clk), .rst_n(rst_n), .ml_i(ml), .mc_i(mc), .md_i(md), .cs_n_i(cs_n),
    .atten_l_o(atten_l), .atten_r_o(atten_r), .mute_o(mute), .deemph_o(deemph),
    .dac_off_o(dac_off), .word_sel_o(word_sel), .i2s_o(i2s), .lr_pol_o(lr_pol),
    .atten_common_o(atten_common), .slow_roll_o(slow_roll), .phase_inv_o(phase_inv),
    .clk_half_o(clk_half), .fs_sel_o(fs_sel), .zero_det_o(zero_det)
  );

  typedef struct {
    logic [29:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;

  // independent model of the register contents
  logic [7:0] m_l = 8'hFF, m_r = 8'hFF;
  logic [4:0] m_core = 5'h00;
  logic [8:0] m_if = 9'h080;

  function automatic logic [29:0] actual_vec();
    return {atten_l, atten_r, mute, deemph, dac_off, word_sel, i2s, lr_pol,
            atten_common, slow_roll, phase_inv, clk_half, fs_sel, zero_det};
  endfunction

  function automatic logic [29:0] expect_vec();
    logic [7:0] r;
    r = m_if[2] ? m_l : m_r;
    return {m_l, r, m_core[0], m_core[1], m_core[2], m_core[4:3], m_if[0], m_if[1],
            m_if[2], m_if[3], m_if[4], m_if[5], m_if[7:6], m_if[8]};
  endfunction

  task automatic model_apply(input logic [15:0] w);
    case (w[10:9])
      2'd0: if (w[8]) m_l = w[7:0];
      2'd1: if (w[8]) m_r = w[7:0];
      2'd2: m_core = w[4:0];
      default: m_if = w[8:0];
    endcase
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string tag);
    item_t it;
    @(posedge clk);
    #1;
    it.exp = expect_vec();
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic write_frame(input logic [31:0] bits, input int nbits,
                             input logic cs_hi, input string tag);
    cs_n = cs_hi;
    wait_clks(PH);
    ml = 1'b0;
    wait_clks(PH);
    for (int i = nbits - 1; i >= 0; i--) begin
      md = bits[i];
      mc = 1'b0;
      wait_clks(PH);
      mc = 1'b1;
      wait_clks(PH);
    end
    mc = 1'b0;
    wait_clks(PH);
    ml = 1'b1;
    wait_clks(10);
    if (!cs_hi && nbits >= 16) model_apply(bits[15:0]);
    push(tag);
  endtask

  // monitor: compare queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [29:0] act;
        it = q.pop_front();
        act = actual_vec();
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  bit done = 1'b0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(4);
    push("R1 reset defaults");

    write_frame(32'h0415, 16, 1'b0, "R3 core fields");
    write_frame(32'h07AB, 16, 1'b0, "R4 interface fields");
    write_frame(32'h0600, 16, 1'b0, "R4 interface clear / R2 routing");
    write_frame(32'h0040, 16, 1'b0, "R5 left code without load held");
    write_frame(32'h0180, 16, 1'b0, "R5 left code with load applied");
    write_frame(32'h0233, 16, 1'b0, "R6 right code without load held");
    write_frame(32'h0333, 16, 1'b0, "R6 right code with load applied");
    write_frame(32'h0604, 16, 1'b0, "R9 common mode right follows left");
    write_frame(32'h0311, 16, 1'b0, "R9 right load during common mode");
    write_frame(32'h0600, 16, 1'b0, "R9 right code returns after common mode");
    write_frame(32'h0407, 16, 1'b1, "R7 select high discards frame");
    write_frame(32'h0407, 12, 1'b0, "R8 short frame discarded");
    write_frame(32'h000F_0403, 20, 1'b0, "R8 long frame keeps last 16 bits");
    write_frame(32'hFDE1, 16, 1'b0, "R3 reserved bits ignored");
    write_frame(32'h01C3, 16, 1'b0, "R2 address 0 leaves other registers");

    wait (q.size() == 0);
    wait_clks(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule